// File: doc/BRIEF.md
# Fixed-Point Requantizer

This block takes a wide signed fixed-point word and narrows it to a smaller signed fixed-point format. A typical source is the result of a multiply-accumulate stage whose sum has grown well beyond the precision the next stage needs. Another is a coefficient that must be stored at a reduced width. The input format has `IN_W` bits, of which `IN_FRAC` are fractional. The output format has `OUT_W` bits, of which `OUT_FRAC` are fractional.

Every low-order bit that is dropped goes through one of five rounding rules, chosen per sample by a 3-bit mode input. Rounding is done first. The rounded value is then compared with the output range. If it does not fit, the block raises an overflow flag. A per-sample policy bit then decides the result: either the value is clamped to the extreme code, or only its low bits are kept (wrap).

The output can be registered (`REG_OUT=1`, the default) or purely combinational (`REG_OUT=0`). The block is meant to sit between an accumulator and its output register. It lets the register and everything downstream be narrower.

Top module: `rq_requant`

## Requirements
- R1: The output code equals the input code scaled by 2^(OUT_FRAC-IN_FRAC), rounded by the selected mode. Mode code 3 rounds toward minus infinity, and the unused codes 5, 6 and 7 behave exactly like code 3.
- R2: Mode code 0 rounds to the nearest output step. A value exactly half-way between two steps moves away from zero.
- R3: Mode code 1 rounds toward zero. A negative input with any nonzero dropped bit ends one step above its floor.
- R4: Mode code 2 rounds toward plus infinity. Any nonzero dropped bit raises the result by one step.
- R5: Mode code 4 rounds to nearest. A value exactly half-way resolves to the step whose least significant bit is 0.
- R6: `out_ovf` is 1 exactly when the rounded value lies outside [-2^(OUT_W-1), 2^(OUT_W-1)-1]. This holds under both overflow policies.
- R7: With `sat_en`=1, an out-of-range result is replaced by the largest code (sign bit 0, all other bits 1) if it is positive. It is replaced by the smallest code (sign bit 1, all other bits 0) if it is negative.
- R8: With `sat_en`=0, the output is the low `OUT_W` bits of the rounded value, two's complement wrap.
- R9: The overflow test applies to the value after rounding. A carry caused by rounding up from the largest code counts as overflow.
- R10: With `REG_OUT`=1, `out_valid` equals `in_valid` one clock earlier. `out_data` and `out_ovf` are loaded only in cycles with `in_valid`=1 and hold otherwise.
- R11: While `rst_n` is low, `out_valid`, `out_data` and `out_ovf` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_data | input | IN_W | Wide signed fixed-point input |
| rnd_mode | input | 3 | Rounding rule: 0 nearest/ties away, 1 toward zero, 2 up, 3 down, 4 nearest/ties even |
| sat_en | input | 1 | 1 clamps out-of-range results, 0 wraps them |
| out_valid | output | 1 | Output sample present |
| out_data | output | OUT_W | Narrowed signed fixed-point output |
| out_ovf | output | 1 | Rounded value was outside the output range |

## Verification
The datapath has no state beyond the output register, so a fault shows at the ports on the very next sample. A wrong increment decision shows as a result off by one step. This appears only for inputs whose dropped bits sit at or near the half-way point, or carry a particular sign. For that reason the vectors group ties, near-ties and exact values of both signs. A broken range test shows as a missing flag, or as a clamp or wrap on the wrong side. A stale output register shows as data changing while `in_valid` is low, or as a sample arriving one cycle late.

// File: rtl/rq_pkg.sv
package rq_pkg;
   // Rounding rule selector codes
   localparam logic [2:0] RQ_NEAREST = 3'd0;   // ties away from zero
   localparam logic [2:0] RQ_ZERO    = 3'd1;   // truncate toward zero
   localparam logic [2:0] RQ_UP      = 3'd2;   // toward +inf
   localparam logic [2:0] RQ_DOWN    = 3'd3;   // toward -inf (also 5..7)
   localparam logic [2:0] RQ_EVEN    = 3'd4;   // ties to even
endpackage

// File: rtl/rq_round.sv
// Drops SHIFT low bits of a signed word and applies the selected rounding
// rule. Result is one bit wider than the kept part so a carry is preserved.
module rq_round
   import rq_pkg::*;
#(
   parameter int IN_W  = 23,
   parameter int SHIFT = 12
) (
   input  logic signed [IN_W-1:0]     x,
   input  logic        [2:0]          mode,
   output logic signed [IN_W-SHIFT:0] r
);
   localparam int QW = IN_W - SHIFT;

   logic signed [QW-1:0] kept;
   logic                 half_bit;
   logic                 below_half;
   logic                 any_drop;
   logic                 neg;
   logic                 bump;

   assign kept     = x[IN_W-1:SHIFT];
   assign half_bit = x[SHIFT-1];
   assign any_drop = |x[SHIFT-1:0];
   assign neg      = x[IN_W-1];

   generate
      if (SHIFT == 1) begin : g_one_drop
         assign below_half = 1'b0;
      end else begin : g_many_drop
         assign below_half = |x[SHIFT-2:0];
      end
   endgenerate

   // Increment decision over the floor value (kept bits)
   always_comb begin
      unique case (mode)
         RQ_NEAREST: bump = half_bit & (below_half | ~neg);      // R2
         RQ_ZERO:    bump = neg & any_drop;                      // R3
         RQ_UP:      bump = any_drop;                            // R4
         RQ_EVEN:    bump = half_bit & (below_half | kept[0]);   // R5
         default:    bump = 1'b0;                                // R1
      endcase
   end

   assign r = {kept[QW-1], kept} + {{QW{1'b0}}, bump};
endmodule

// File: rtl/rq_clip.sv
// Range test of the rounded value and the overflow policy (R6, R7, R8).
module rq_clip #(
   parameter int RW    = 12,
   parameter int OUT_W = 8
) (
   input  logic signed [RW-1:0]    r,
   input  logic                    sat_en,
   output logic        [OUT_W-1:0] y,
   output logic                    ovf
);
   localparam int TOPW = RW - OUT_W + 1;

   logic [TOPW-1:0]  top;
   logic [OUT_W-1:0] hi_code;
   logic [OUT_W-1:0] lo_code;

   assign top     = r[RW-1:OUT_W-1];
   assign ovf     = ~((&top) | ~(|top));
   assign hi_code = {1'b0, {(OUT_W-1){1'b1}}};
   assign lo_code = {1'b1, {(OUT_W-1){1'b0}}};

   always_comb begin
      if (ovf && sat_en) y = r[RW-1] ? lo_code : hi_code;
      else               y = r[OUT_W-1:0];
   end
endmodule

// File: rtl/rq_requant.sv
module rq_requant #(
   parameter int IN_W     = 23,
   parameter int IN_FRAC  = 16,
   parameter int OUT_W    = 8,
   parameter int OUT_FRAC = 4,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_data,
   input  logic [2:0]       rnd_mode,
   input  logic             sat_en,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data,
   output logic             out_ovf
);
   localparam int SHIFT = IN_FRAC - OUT_FRAC;
   localparam int RW    = IN_W - SHIFT + 1;

   generate
      if (SHIFT < 1) begin : g_bad_shift
         $error("rq_requant: OUT_FRAC must be below IN_FRAC");
      end
      if (RW - 1 < OUT_W) begin : g_bad_int
         $error("rq_requant: output has more integer bits than input");
      end
      if (OUT_W < 2) begin : g_bad_out
         $error("rq_requant: OUT_W must be at least 2");
      end
   endgenerate

   logic signed [RW-1:0] rounded;
   logic [OUT_W-1:0]     narrow;
   logic                 range_err;

   rq_round #(.IN_W(IN_W), .SHIFT(SHIFT)) u_round (
      .x    (in_data),
      .mode (rnd_mode),
      .r    (rounded)
   );

   // Range is checked on the rounded value (R9)
   rq_clip #(.RW(RW), .OUT_W(OUT_W)) u_clip (
      .r      (rounded),
      .sat_en (sat_en),
      .y      (narrow),
      .ovf    (range_err)
   );

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               out_data  <= '0;
               out_ovf   <= 1'b0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  out_data <= narrow;
                  out_ovf  <= range_err;
               end
            end
         end
      end else begin : g_comb
         assign out_valid = in_valid;
         assign out_data  = narrow;
         assign out_ovf   = range_err;
      end
   endgenerate
endmodule

// File: rtl/rq_requant_chk.sv
module rq_requant_chk #(
   parameter int IN_W    = 23,
   parameter int OUT_W   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [IN_W-1:0]  in_data,
   input logic             sat_en,
   input logic             out_valid,
   input logic [OUT_W-1:0] out_data,
   input logic             out_ovf
);
   localparam logic [OUT_W-1:0] HI = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] LO = {1'b1, {(OUT_W-1){1'b0}}};

   generate
      if (REG_OUT) begin : g_chk
         p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> out_valid == $past(in_valid));

         p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(in_valid)) |-> ($stable(out_data) && $stable(out_ovf)));

         p_sat_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_valid) && $past(sat_en) && out_ovf)
               |-> (out_data == HI || out_data == LO));

         p_sat_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_valid) && $past(sat_en) && out_ovf)
               |-> out_data[OUT_W-1] == $past(in_data[IN_W-1]));

         p_reset_r11: assert property (@(posedge clk)
            !rst_n |-> (!out_valid && !out_ovf && out_data == '0));
      end
   endgenerate
endmodule

bind rq_requant rq_requant_chk #(
   .IN_W(IN_W), .OUT_W(OUT_W), .REG_OUT(REG_OUT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
   .sat_en(sat_en), .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf)
);

// File: tb/test_rq_requant.sv
`timescale 1ns/1ps
module test_rq_requant;
   // Q6.6 in, Q4.2 out: 4 dropped bits, output step = 16 input codes
   localparam int IW = 12;
   localparam int OW = 6;

   typedef struct packed {
      logic [2:0]           m;
      logic                 s;
      logic signed [IW-1:0] x;
      logic signed [OW-1:0] y;
      logic                 o;
   } vec_t;

   localparam int NV = 36;
   localparam vec_t VEC [NV] = '{
      '{3'd0, 1'b1,  12'sd40,   6'sd3,  1'b0},
      '{3'd1, 1'b1,  12'sd40,   6'sd2,  1'b0},
      '{3'd2, 1'b1,  12'sd40,   6'sd3,  1'b0},
      '{3'd3, 1'b1,  12'sd40,   6'sd2,  1'b0},
      '{3'd4, 1'b1,  12'sd40,   6'sd2,  1'b0},
      '{3'd4, 1'b1,  12'sd56,   6'sd4,  1'b0},
      '{3'd0, 1'b1,  12'sd56,   6'sd4,  1'b0},
      '{3'd0, 1'b1, -12'sd40,  -6'sd3,  1'b0},
      '{3'd1, 1'b1, -12'sd40,  -6'sd2,  1'b0},
      '{3'd2, 1'b1, -12'sd40,  -6'sd2,  1'b0},
      '{3'd3, 1'b1, -12'sd40,  -6'sd3,  1'b0},
      '{3'd4, 1'b1, -12'sd40,  -6'sd2,  1'b0},
      '{3'd4, 1'b1, -12'sd41,  -6'sd3,  1'b0},
      '{3'd1, 1'b1, -12'sd41,  -6'sd2,  1'b0},
      '{3'd0, 1'b1, -12'sd39,  -6'sd2,  1'b0},
      '{3'd1, 1'b1, -12'sd48,  -6'sd3,  1'b0},
      '{3'd0, 1'b1, -12'sd8,   -6'sd1,  1'b0},
      '{3'd4, 1'b1, -12'sd8,    6'sd0,  1'b0},
      '{3'd4, 1'b1,  12'sd8,    6'sd0,  1'b0},
      '{3'd0, 1'b1,  12'sd8,    6'sd1,  1'b0},
      '{3'd4, 1'b1,  12'sd24,   6'sd2,  1'b0},
      '{3'd1, 1'b1, -12'sd24,  -6'sd1,  1'b0},
      '{3'd3, 1'b1,  12'sd500,  6'sd31, 1'b0},
      '{3'd2, 1'b1,  12'sd500,  6'sd31, 1'b1},
      '{3'd2, 1'b0,  12'sd500, -6'sd32, 1'b1},
      '{3'd3, 1'b1, -12'sd513, -6'sd32, 1'b1},
      '{3'd3, 1'b0, -12'sd513,  6'sd31, 1'b1},
      '{3'd2, 1'b1, -12'sd513, -6'sd32, 1'b0},
      '{3'd0, 1'b1,  12'sd2047, 6'sd31, 1'b1},
      '{3'd3, 1'b0,  12'sd2047,-6'sd1,  1'b1},
      '{3'd3, 1'b0, -12'sd2048, 6'sd0,  1'b1},
      '{3'd3, 1'b1, -12'sd2048,-6'sd32, 1'b1},
      '{3'd5, 1'b1,  12'sd40,   6'sd2,  1'b0},
      '{3'd7, 1'b1, -12'sd40,  -6'sd3,  1'b0},
      '{3'd0, 1'b0,  12'sd496,  6'sd31, 1'b0},
      '{3'd1, 1'b0, -12'sd512, -6'sd32, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [IW-1:0] in_data = '0;
   logic [2:0]    rnd_mode = 3'd0;
   logic          sat_en = 1'b0;
   logic          out_valid;
   logic [OW-1:0] out_data;
   logic          out_ovf;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   rq_requant #(.IN_W(IW), .IN_FRAC(6), .OUT_W(OW), .OUT_FRAC(2), .REG_OUT(1'b1)) i_rq_requant (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .rnd_mode(rnd_mode), .sat_en(sat_en), .out_valid(out_valid),
      .out_data(out_data), .out_ovf(out_ovf)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic string req_of(input vec_t v);
      if (v.o && v.s)  return "R7";
      if (v.o)         return "R8";
      case (v.m)
         3'd0:    return "R2";
         3'd1:    return "R3";
         3'd2:    return "R4";
         3'd4:    return "R5";
         default: return "R1";
      endcase
   endfunction

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   endtask

   // Drive at negedge, result registered at next posedge, sample at negedge
   task automatic apply(input logic [2:0] m, input logic s, input logic [IW-1:0] x);
      rnd_mode = m; sat_en = s; in_data = x; in_valid = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R11: reset state
      repeat (2) @(negedge clk);
      check("R11 valid", int'(out_valid), 0);
      check("R11 data", int'(out_data), 0);
      check("R11 ovf", int'(out_ovf), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: R1-style rounding modes, overflow flag R6, policies R7/R8
      for (int i = 0; i < NV; i++) begin
         apply(VEC[i].m, VEC[i].s, VEC[i].x);
         check(req_of(VEC[i]), int'($signed(out_data)), int'(VEC[i].y));
         check("R6 ovf flag", int'(out_ovf), int'(VEC[i].o));
         check("R10 valid", int'(out_valid), 1);
      end

      // R9: exact largest code, ceil with tiny excess carries into overflow
      apply(3'd2, 1'b1, 12'sd496);
      check("R9 exact max ovf", int'(out_ovf), 0);
      apply(3'd2, 1'b1, 12'sd497);
      check("R9 carry ovf", int'(out_ovf), 1);
      check("R9 carry clamp", int'($signed(out_data)), 31);

      // R10: hold while in_valid low
      apply(3'd0, 1'b1, 12'sd40);
      in_valid = 1'b0; in_data = -12'sd1000; rnd_mode = 3'd2;
      @(negedge clk);
      check("R10 valid drop", int'(out_valid), 0);
      @(negedge clk);
      check("R10 hold data", int'($signed(out_data)), 3);
      check("R10 hold ovf", int'(out_ovf), 0);

      // R11: reset mid-run clears registered state
      apply(3'd0, 1'b1, 12'sd2047);
      rst_n = 1'b0;
      #1;
      check("R11 async data", int'(out_data), 0);
      check("R11 async ovf", int'(out_ovf), 0);
      check("R11 async valid", int'(out_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;
      in_valid = 1'b0;
      @(negedge clk);
      finish_run();
   end
endmodule